// File: doc/BRIEF.md
# Hardware Ticket Lock Engine

This block holds a small set of ticket locks and serves them to several requester ports at once. Each lock has a dispense counter and a serving counter, both cleared by reset. A requester takes a ticket with an acquire, which returns the dispense count and advances it in a single atomic step, whether or not the lock is currently held. It then polls until the serving count reaches its ticket. The holder gives up the lock with a release, which advances the serving count and so hands the lock to the next ticket in line.

Every response also carries the distance from the ticket to the serving count, modulo the counter width. Software can use it to wait for a time in proportion to the number of holders ahead before it polls again. Requests that arrive in the same cycle are applied in port order, lowest index first, and each one sees the effect of the ports before it. Responses appear one cycle after the request.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset every lock has dispense and serving counts of zero and no response is valid; a poll of any lock with ticket 0 reports owned with serving 0.
- R2: An acquire (op code 0) returns the lock's current dispense count as its ticket and advances that count by one, also while the lock is held; the response reports owned when the ticket equals the serving count.
- R3: A poll (op code 2) returns the serving count of the addressed lock and sets the owned bit exactly when it equals the supplied ticket; it changes no counter.
- R4: A release (op code 1) on a lock with at least one ticket outstanding advances the serving count by one and returns the new serving count, with the number of tickets still waiting as its distance.
- R5: Requests from several ports in one cycle are applied in ascending port order, each seeing the state left by lower ports, so simultaneous acquires of one lock get consecutive, distinct tickets in port order.
- R6: The distance field is the ticket minus the serving count, modulo 2^TICKET_W: the queue length ahead for an acquire, and supplied ticket minus serving count for a poll.
- R7: Both counters wrap modulo 2^TICKET_W, and tickets, distances and the owned bit stay correct across the wrap.
- R8: A release on a lock whose serving count equals its dispense count sets the error bit, returns the unchanged serving count and leaves both counters as they were.
- R9: An acquire on a lock that already has 2^TICKET_W-1 tickets outstanding sets the error bit, returns the dispense count with the full distance and leaves both counters unchanged.
- R10: A valid request produces a response exactly one cycle later; op code 3 and cycles without a valid request produce no response and change no counter.
- R11: Operations on one lock never change the counters of another lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_PORTS | Request valid per port |
| req_op_i | input | NUM_PORTS x 2 | Operation per port: 0 acquire, 1 release, 2 poll, 3 reserved |
| req_lock_i | input | NUM_PORTS x LOCK_W | Lock index per port |
| req_ticket_i | input | NUM_PORTS x TICKET_W | Ticket to compare on a poll |
| resp_valid_o | output | NUM_PORTS | Response valid per port |
| resp_ticket_o | output | NUM_PORTS x TICKET_W | Issued ticket (acquire) or serving count (release, poll) |
| resp_ahead_o | output | NUM_PORTS x TICKET_W | Distance for backoff |
| resp_owned_o | output | NUM_PORTS | Ticket equals serving count |
| resp_err_o | output | NUM_PORTS | Release on empty lock or acquire on full lock |

## Verification
The bench builds the unit with three ports, two locks and a 3-bit ticket. The narrow ticket lets a short run fill a lock to seven outstanding tickets and see the full-queue refusal, then drain it, see the empty release refused, and carry both counters through the wrap from 7 to 0. Three ports are enough to put an acquire, a release and a poll on one lock in the same cycle and to check that each sees the lower ports' effects. A second lock shows that locks stay separate.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  typedef enum logic [1:0] {
    OP_ACQ  = 2'd0,
    OP_REL  = 2'd1,
    OP_POLL = 2'd2,
    OP_RSV  = 2'd3
  } tlu_op_e;
endpackage

// File: rtl/tlu_stage.sv
// One port's operation applied to the running lock state.
module tlu_stage
  import tlu_pkg::*;
#(
  parameter int NUM_LOCKS = 4,
  parameter int TICKET_W  = 4,
  parameter int LOCK_W    = 2
) (
  input  logic [NUM_LOCKS-1:0][TICKET_W-1:0] next_i,
  input  logic [NUM_LOCKS-1:0][TICKET_W-1:0] serv_i,
  input  logic                               valid_i,
  input  logic [1:0]                         op_i,
  input  logic [LOCK_W-1:0]                  lock_i,
  input  logic [TICKET_W-1:0]                ticket_i,
  output logic [NUM_LOCKS-1:0][TICKET_W-1:0] next_o,
  output logic [NUM_LOCKS-1:0][TICKET_W-1:0] serv_o,
  output logic                               rsp_valid_o,
  output logic [TICKET_W-1:0]                rsp_ticket_o,
  output logic [TICKET_W-1:0]                rsp_ahead_o,
  output logic                               rsp_owned_o,
  output logic                               rsp_err_o
);
  logic [TICKET_W-1:0] nx, sv, outstanding;
  tlu_op_e op;

  assign op          = tlu_op_e'(op_i);
  assign nx          = next_i[lock_i];
  assign sv          = serv_i[lock_i];
  assign outstanding = nx - sv;

  always_comb begin
    next_o       = next_i;
    serv_o       = serv_i;
    rsp_valid_o  = 1'b0;
    rsp_ticket_o = '0;
    rsp_ahead_o  = '0;
    rsp_owned_o  = 1'b0;
    rsp_err_o    = 1'b0;
    if (valid_i) begin
      unique case (op)
        OP_ACQ: begin
          rsp_valid_o  = 1'b1;
          rsp_ticket_o = nx;
          rsp_ahead_o  = outstanding;
          if (&outstanding) begin
            rsp_err_o = 1'b1;  // one more would alias the serving count
          end else begin
            rsp_owned_o    = (outstanding == '0);
            next_o[lock_i] = nx + 1'b1;
          end
        end
        OP_REL: begin
          rsp_valid_o = 1'b1;
          if (outstanding == '0) begin
            rsp_err_o    = 1'b1;
            rsp_ticket_o = sv;
          end else begin
            serv_o[lock_i] = sv + 1'b1;
            rsp_ticket_o   = sv + 1'b1;
            rsp_ahead_o    = outstanding - 1'b1;
          end
        end
        OP_POLL: begin
          rsp_valid_o  = 1'b1;
          rsp_ticket_o = sv;
          rsp_ahead_o  = ticket_i - sv;
          rsp_owned_o  = (ticket_i == sv);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlu_lock_bank.sv
module tlu_lock_bank #(
  parameter int NUM_PORTS = 3,
  parameter int NUM_LOCKS = 4,
  parameter int TICKET_W  = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_LOCKS-1:0][TICKET_W-1:0] next_d,
  input  logic [NUM_LOCKS-1:0][TICKET_W-1:0] serv_d,
  output logic [NUM_LOCKS-1:0][TICKET_W-1:0] next_q,
  output logic [NUM_LOCKS-1:0][TICKET_W-1:0] serv_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      serv_q <= '0;
    end else begin
      next_q <= next_d;
      serv_q <= serv_d;
    end
  end

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_chk
    // R2: dispense count only advances, at most one step per port
    a_r2_next_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      TICKET_W'(next_q[l] - $past(next_q[l])) <= TICKET_W'(NUM_PORTS));
    // R4: serving count only advances, at most one step per port
    a_r4_serv_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      TICKET_W'(serv_q[l] - $past(serv_q[l])) <= TICKET_W'(NUM_PORTS));
  end
endmodule

// File: rtl/tlu_resp_reg.sv
module tlu_resp_reg #(
  parameter int NUM_PORTS = 3,
  parameter int TICKET_W  = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_PORTS-1:0]               valid_d,
  input  logic [NUM_PORTS-1:0][TICKET_W-1:0] ticket_d,
  input  logic [NUM_PORTS-1:0][TICKET_W-1:0] ahead_d,
  input  logic [NUM_PORTS-1:0]               owned_d,
  input  logic [NUM_PORTS-1:0]               err_d,
  output logic [NUM_PORTS-1:0]               valid_q,
  output logic [NUM_PORTS-1:0][TICKET_W-1:0] ticket_q,
  output logic [NUM_PORTS-1:0][TICKET_W-1:0] ahead_q,
  output logic [NUM_PORTS-1:0]               owned_q,
  output logic [NUM_PORTS-1:0]               err_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= '0;
      ticket_q <= '0;
      ahead_q  <= '0;
      owned_q  <= '0;
      err_q    <= '0;
    end else begin
      valid_q  <= valid_d;
      ticket_q <= ticket_d;
      ahead_q  <= ahead_d;
      owned_q  <= owned_d;
      err_q    <= err_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R3, R6: ownership means nobody is ahead
    a_r3_owned_ahead: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q[p] && owned_q[p]) |-> (ahead_q[p] == '0));
  end
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter  int NUM_PORTS = 3,
  parameter  int NUM_LOCKS = 4,
  parameter  int TICKET_W  = 4,
  localparam int LOCK_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_PORTS-1:0]               req_valid_i,
  input  logic [NUM_PORTS-1:0][1:0]          req_op_i,
  input  logic [NUM_PORTS-1:0][LOCK_W-1:0]   req_lock_i,
  input  logic [NUM_PORTS-1:0][TICKET_W-1:0] req_ticket_i,
  output logic [NUM_PORTS-1:0]               resp_valid_o,
  output logic [NUM_PORTS-1:0][TICKET_W-1:0] resp_ticket_o,
  output logic [NUM_PORTS-1:0][TICKET_W-1:0] resp_ahead_o,
  output logic [NUM_PORTS-1:0]               resp_owned_o,
  output logic [NUM_PORTS-1:0]               resp_err_o
);
  logic [NUM_LOCKS-1:0][TICKET_W-1:0] next_q, serv_q;
  logic [NUM_LOCKS-1:0][TICKET_W-1:0] chain_next [NUM_PORTS+1];
  logic [NUM_LOCKS-1:0][TICKET_W-1:0] chain_serv [NUM_PORTS+1];
  logic [NUM_PORTS-1:0]               st_valid, st_owned, st_err;
  logic [NUM_PORTS-1:0][TICKET_W-1:0] st_ticket, st_ahead;

  assign chain_next[0] = next_q;
  assign chain_serv[0] = serv_q;

  // Fixed priority: port p sees the state left by ports 0..p-1.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tlu_stage #(
      .NUM_LOCKS(NUM_LOCKS),
      .TICKET_W (TICKET_W),
      .LOCK_W   (LOCK_W)
    ) i_stage (
      .next_i      (chain_next[p]),
      .serv_i      (chain_serv[p]),
      .valid_i     (req_valid_i[p]),
      .op_i        (req_op_i[p]),
      .lock_i      (req_lock_i[p]),
      .ticket_i    (req_ticket_i[p]),
      .next_o      (chain_next[p+1]),
      .serv_o      (chain_serv[p+1]),
      .rsp_valid_o (st_valid[p]),
      .rsp_ticket_o(st_ticket[p]),
      .rsp_ahead_o (st_ahead[p]),
      .rsp_owned_o (st_owned[p]),
      .rsp_err_o   (st_err[p])
    );

    // R10: one-cycle response for every real operation, none otherwise
    a_r10_resp_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[p] && (req_op_i[p] != 2'b11)) |=> resp_valid_o[p]);
    a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_valid_i[p] && (req_op_i[p] != 2'b11)) |=> !resp_valid_o[p]);
  end

  tlu_lock_bank #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LOCKS(NUM_LOCKS),
    .TICKET_W (TICKET_W)
  ) i_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .next_d(chain_next[NUM_PORTS]),
    .serv_d(chain_serv[NUM_PORTS]),
    .next_q(next_q),
    .serv_q(serv_q)
  );

  tlu_resp_reg #(
    .NUM_PORTS(NUM_PORTS),
    .TICKET_W (TICKET_W)
  ) i_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_d (st_valid),
    .ticket_d(st_ticket),
    .ahead_d (st_ahead),
    .owned_d (st_owned),
    .err_d   (st_err),
    .valid_q (resp_valid_o),
    .ticket_q(resp_ticket_o),
    .ahead_q (resp_ahead_o),
    .owned_q (resp_owned_o),
    .err_q   (resp_err_o)
  );

  // R10: idle cycles leave every counter alone
  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_valid_i) |=> ($stable(next_q) && $stable(serv_q)));
endmodule

// File: tb/test_ticket_lock_unit.sv
module test_ticket_lock_unit;
  localparam int P = 3;
  localparam int L = 2;
  localparam int W = 3;
  localparam int LW = 1;

  typedef struct packed {
    logic [P-1:0]        v;
    logic [P-1:0][W-1:0] t;
    logic [P-1:0][W-1:0] a;
    logic [P-1:0]        o;
    logic [P-1:0]        e;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0]         req_valid = '0;
  logic [P-1:0][1:0]    req_op = '0;
  logic [P-1:0][LW-1:0] req_lock = '0;
  logic [P-1:0][W-1:0]  req_ticket = '0;
  logic [P-1:0]         resp_valid, resp_owned, resp_err;
  logic [P-1:0][W-1:0]  resp_ticket, resp_ahead;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  exp_t  expq[$];
  string tagq[$];
  logic [W-1:0] m_next [L];
  logic [W-1:0] m_serv [L];

  always #4 clk = ~clk;  // 125 MHz

  ticket_lock_unit #(.NUM_PORTS(P), .NUM_LOCKS(L), .TICKET_W(W)) i_ticket_lock_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_lock_i(req_lock),
    .req_ticket_i(req_ticket),
    .resp_valid_o(resp_valid), .resp_ticket_o(resp_ticket),
    .resp_ahead_o(resp_ahead), .resp_owned_o(resp_owned), .resp_err_o(resp_err)
  );

  task automatic clear_req();
    req_valid = '0;
    req_op = '0;
    req_lock = '0;
    req_ticket = '0;
  endtask

  task automatic set_req(input int p, input logic [1:0] op, input int lk, input int tk);
    req_valid[p] = 1'b1;
    req_op[p] = op;
    req_lock[p] = LW'(lk);
    req_ticket[p] = W'(tk);
  endtask

  // Driver: model the requested behaviour port by port, queue the result, wait a cycle.
  task automatic go(input string tag);
    exp_t x;
    x = '0;
    for (int p = 0; p < P; p++) begin
      int lk;
      logic [W-1:0] outs;
      lk = int'(req_lock[p]);
      outs = m_next[lk] - m_serv[lk];
      if (req_valid[p]) begin
        case (req_op[p])
          2'd0: begin
            x.v[p] = 1'b1; x.t[p] = m_next[lk]; x.a[p] = outs;
            if (outs == W'(7)) x.e[p] = 1'b1;
            else begin
              x.o[p] = (outs == '0);
              m_next[lk] = m_next[lk] + 1'b1;
            end
          end
          2'd1: begin
            x.v[p] = 1'b1;
            if (outs == '0) begin
              x.e[p] = 1'b1; x.t[p] = m_serv[lk];
            end else begin
              m_serv[lk] = m_serv[lk] + 1'b1;
              x.t[p] = m_serv[lk]; x.a[p] = outs - 1'b1;
            end
          end
          2'd2: begin
            x.v[p] = 1'b1; x.t[p] = m_serv[lk];
            x.a[p] = req_ticket[p] - m_serv[lk];
            x.o[p] = (req_ticket[p] == m_serv[lk]);
          end
          default: ;
        endcase
      end
    end
    expq.push_back(x);
    tagq.push_back(tag);
    @(negedge clk);
    clear_req();
  endtask

  // Monitor: compare each queued expectation with the registered response.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        exp_t x;
        string tag;
        x = expq.pop_front();
        tag = tagq.pop_front();
        for (int p = 0; p < P; p++) begin
          checks++;
          if (resp_valid[p] !== x.v[p] ||
              (x.v[p] && (resp_ticket[p] !== x.t[p] || resp_ahead[p] !== x.a[p] ||
                          resp_owned[p] !== x.o[p] || resp_err[p] !== x.e[p]))) begin
            failures++;
            $display("FAIL %s port%0d: got v=%b t=%0d a=%0d o=%b e=%b exp v=%b t=%0d a=%0d o=%b e=%b",
                     tag, p, resp_valid[p], resp_ticket[p], resp_ahead[p], resp_owned[p],
                     resp_err[p], x.v[p], x.t[p], x.a[p], x.o[p], x.e[p]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < L; l++) begin
      m_next[l] = '0;
      m_serv[l] = '0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (resp_valid !== '0) begin
      failures++;
      $display("FAIL R1 reset: got valid=%b expected 000", resp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    set_req(0, 2'd2, 0, 0); set_req(1, 2'd2, 1, 0); go("R1");
    set_req(1, 2'd0, 0, 0); go("R2");            // ticket 0, owned
    set_req(0, 2'd0, 0, 0); go("R2");            // held: ticket 1, ahead 1
    set_req(2, 2'd2, 0, 1); go("R3");            // not yet owned
    set_req(0, 2'd0, 0, 0); set_req(1, 2'd0, 0, 0); set_req(2, 2'd0, 0, 0);
    go("R5");                                    // tickets 2,3,4 in port order
    set_req(1, 2'd1, 0, 0); go("R4");
    set_req(0, 2'd2, 0, 1); set_req(1, 2'd2, 0, 4); go("R6");
    set_req(0, 2'd1, 0, 0); set_req(2, 2'd0, 1, 0); go("R11");
    set_req(0, 2'd3, 0, 0); set_req(1, 2'd2, 0, 2); go("R10");
    set_req(2, 2'd3, 1, 0); go("R10");
    set_req(0, 2'd2, 0, 2); set_req(1, 2'd2, 1, 1); go("R10");
    // drain lock 0, then release once more
    for (int i = 0; i < 3; i++) begin
      set_req(i % P, 2'd1, 0, 0); go("R4");
    end
    set_req(2, 2'd1, 0, 0); go("R8");
    set_req(0, 2'd2, 0, 5); set_req(1, 2'd1, 0, 0); go("R8");
    // fill lock 1 to the limit (one ticket taken already)
    for (int i = 0; i < 6; i++) begin
      set_req(i % P, 2'd0, 1, 0); go("R9");
    end
    set_req(1, 2'd0, 1, 0); set_req(2, 2'd2, 1, 7); go("R9");
    set_req(0, 2'd2, 1, 0); go("R9");
    // drain lock 1 and wrap both counters
    for (int i = 0; i < 7; i++) begin
      set_req(i % P, 2'd1, 1, 0); go("R7");
    end
    set_req(0, 2'd0, 1, 0); set_req(1, 2'd0, 1, 0); go("R7"); // tickets 7, 0
    set_req(2, 2'd2, 1, 0); go("R7");
    set_req(0, 2'd1, 1, 0); set_req(1, 2'd2, 1, 0); go("R7");
    // mixed ops on one lock in one cycle
    set_req(0, 2'd0, 0, 0); set_req(1, 2'd1, 0, 0); set_req(2, 2'd2, 0, 6); go("R5");
    set_req(0, 2'd1, 0, 0); set_req(1, 2'd0, 0, 0); set_req(2, 2'd1, 0, 0); go("R5");
    set_req(0, 2'd2, 0, 7); set_req(1, 2'd2, 1, 1); go("R11");
    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0 || resp_valid !== '0) begin
      failures++;
      $display("FAIL R10 idle: got pending=%0d valid=%b expected 0 000", expq.size(), resp_valid);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule